// File: doc/BRIEF.md
# Hash Engine Control Register Block

This block is the software-facing front end of a DMA-driven hash accelerator. A 32-bit bus slave with word addressing holds the address and length registers that the datapath reads: source, destination, key buffer and source length. It also holds a cipher command word and a status word. Bits in the status word are cleared by writing a one. A write to the hash command word is decoded into an algorithm code, a mode and a scatter-gather flag. If the selection is legal and no operation is running, the block emits a one-cycle start pulse that carries those fields.

The datapath reports completion on a done input. Completion always records a done bit in the status word. The single interrupt line is raised only when the command that launched the operation asked for it. A command written while an operation is in flight is refused and recorded in a sticky error bit. HMAC, key preparation and cascaded cipher modes are not carried out here. They are flagged on an output so that the datapath can handle or reject them.

Top module: `hash_ctrl_regs`

## Requirements
- R1: Register word indices are: 4 cipher command, 7 status, 8 source address, 9 destination address, 10 key address, 11 source length, 12 hash command. Any other word below the range limit (default 16) reads zero, and writes to it are dropped. The source, destination, key and length values also appear on output ports.
- R2: Written values are masked as follows:
  - source address keeps bits 30:0
  - destination and key addresses keep bits 30:3, so their low three bits read zero
  - length keeps bits 27:0
  - hash command keeps bits 20, 18 and 14:0
- R3: A read at a word index at or above the range limit returns zero. A write there changes no register.
- R4: Command bits 6:4 select a family and bits 12:10 a sub-select. The start pulse carries an algorithm code:
  - family 000 with sub 000 gives code 0 (MD5)
  - family 010 with sub 000 gives code 1 (SHA-1)
  - family 100 with sub 000 gives code 2 (SHA-224)
  - family 101 with sub 000 gives code 3 (SHA-256)
  - family 110 with sub 000 gives code 4 (SHA-512)
  - family 110 with sub 001 gives code 5 (SHA-384)
  - family 110 with sub 010 gives code 6 (truncated 256-bit output of the 64-bit family)
- R5: Every other combination of family and sub-select is invalid. An invalid command gives no start pulse and starts no operation, so a later done pulse has no effect.
- R6: An accepted command gives a start pulse exactly one cycle long, in the cycle after the write. With it come the mode from command bits 8:7 (00 digest, 01 HMAC, 10 accumulate, 11 key preparation) and the scatter-gather flag from command bit 18.
- R7: The unsupported output holds 1 for the last accepted command if its mode was 01 or 11, or if its bit 1 (cascade) was set. Otherwise it holds 0.
- R8: A done pulse while an operation runs sets status bit 9, whether or not the interrupt was enabled. A done pulse with no operation running is ignored.
- R9: The interrupt rises on completion only if bit 9 of the launching command was 1. Writing 1 to status bit 9 clears that bit and lowers the interrupt.
- R10: A hash command written while busy is refused: no start pulse, and the stored command is unchanged. It sets sticky status bit 0, which is cleared by writing 1 to bit 0.
- R11: Writing ones to the status word never sets a bit. Status bits 12 and 15 (cipher and tag done) read zero.
- R12: Reset clears every register and the status word, lowers the interrupt and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word index |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid while rd_en is high, zero otherwise |
| done_in | input | 1 | Completion pulse from the datapath |
| start | output | 1 | One-cycle launch pulse |
| start_algo | output | 3 | Algorithm code of the launched operation |
| start_mode | output | 2 | Mode of the launched operation |
| start_sg | output | 1 | Scatter-gather input requested |
| unsupported | output | 1 | Launched command uses a mode not handled here |
| src_addr | output | DATA_W | Source address register |
| dst_addr | output | DATA_W | Destination address register |
| key_addr | output | DATA_W | Key buffer address register |
| src_len | output | DATA_W | Source length register |
| irq | output | 1 | Interrupt line |

## Verification
The decoder is driven with every legal family and sub-select pair, and with three kinds of illegal pair:
- a sub-select outside the 64-bit family's range
- a family code that is not defined
- a legal 32-bit-word family with a nonzero sub-select

Together these separate a decoder that checks both fields from one that looks only at the family. The same command table varies the interrupt-enable, scatter-gather, mode and cascade bits, and puts bits outside the command mask into one entry. Each field and the unsupported flag are therefore shown to be decoded independently. Directed sequences cover:
- a command written while busy
- a done pulse while idle
- an attempt to set status bits by writing ones
- address masking and out-of-range access
- reset during a pending interrupt

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    typedef enum logic [2:0] {
        ALG_MD5       = 3'd0,
        ALG_SHA1      = 3'd1,
        ALG_SHA224    = 3'd2,
        ALG_SHA256    = 3'd3,
        ALG_SHA512    = 3'd4,
        ALG_SHA384    = 3'd5,
        ALG_SHA512T   = 3'd6
    } hcr_alg_e;

    typedef enum logic [1:0] {
        MODE_DIGEST  = 2'd0,
        MODE_HMAC    = 2'd1,
        MODE_ACCUM   = 2'd2,
        MODE_KEYPREP = 2'd3
    } hcr_mode_e;

    // word indices on the bus
    localparam int IDX_CCMD = 4;
    localparam int IDX_STAT = 7;
    localparam int IDX_SRC  = 8;
    localparam int IDX_DST  = 9;
    localparam int IDX_KEY  = 10;
    localparam int IDX_LEN  = 11;
    localparam int IDX_HCMD = 12;

    // command field positions
    localparam int CMD_FAM_LSB  = 4;
    localparam int CMD_SUB_LSB  = 10;
    localparam int CMD_MODE_LSB = 7;
    localparam int CMD_IRQ_BIT  = 9;
    localparam int CMD_SG_BIT   = 18;
    localparam int CMD_CASC_BIT = 1;

    // status bit positions
    localparam int ST_ERR_BIT  = 0;
    localparam int ST_DONE_BIT = 9;

    typedef struct packed {
        logic      valid;
        hcr_alg_e  algo;
        hcr_mode_e mode;
        logic      sg;
        logic      irq_en;
        logic      unsup;
    } hcr_cmd_t;

endpackage

// File: rtl/hcr_cmd_decode.sv
module hcr_cmd_decode
    import hcr_pkg::*;
(
    input  logic [2:0] fam,
    input  logic [2:0] sub,
    input  logic [1:0] mode,
    input  logic       sg,
    input  logic       irq_en,
    input  logic       casc,
    output hcr_cmd_t   dec
);

    always_comb begin
        dec.valid  = 1'b1;
        dec.algo   = ALG_MD5;
        dec.mode   = hcr_mode_e'(mode);
        dec.sg     = sg;
        dec.irq_en = irq_en;
        dec.unsup  = casc || (mode == MODE_HMAC) || (mode == MODE_KEYPREP);
        unique case (fam)
            3'b000:  dec.algo = ALG_MD5;
            3'b010:  dec.algo = ALG_SHA1;
            3'b100:  dec.algo = ALG_SHA224;
            3'b101:  dec.algo = ALG_SHA256;
            3'b110: begin
                unique case (sub)
                    3'b000:  dec.algo = ALG_SHA512;
                    3'b001:  dec.algo = ALG_SHA384;
                    3'b010:  dec.algo = ALG_SHA512T;
                    default: dec.valid = 1'b0;
                endcase
            end
            default: dec.valid = 1'b0;
        endcase
        // the 32-bit-word families accept only a zero sub-select
        if (fam != 3'b110 && sub != 3'b000) begin
            dec.valid = 1'b0;
        end
    end

endmodule

// File: rtl/hcr_op_ctrl.sv
module hcr_op_ctrl
    import hcr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_wr,
    input  hcr_cmd_t  dec,
    input  logic      done_in,
    input  logic      clr_done,
    input  logic      clr_err,
    output logic      accept,
    output logic      start,
    output hcr_alg_e  algo,
    output hcr_mode_e mode,
    output logic      sg,
    output logic      unsup,
    output logic      done_bit,
    output logic      err_bit,
    output logic      irq
);

    typedef struct packed {
        logic      start;
        logic      busy;
        logic      irq_en;
        hcr_alg_e  algo;
        hcr_mode_e mode;
        logic      sg;
        logic      unsup;
        logic      done_bit;
        logic      err_bit;
        logic      irq;
    } op_state_t;

    op_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        accept     = cmd_wr && !st_q.busy;
        if (cmd_wr) begin
            if (st_q.busy) begin
                st_d.err_bit = 1'b1;
            end else if (dec.valid) begin
                st_d.start  = 1'b1;
                st_d.busy   = 1'b1;
                st_d.irq_en = dec.irq_en;
                st_d.algo   = dec.algo;
                st_d.mode   = dec.mode;
                st_d.sg     = dec.sg;
                st_d.unsup  = dec.unsup;
            end
        end
        if (clr_done) begin
            st_d.done_bit = 1'b0;
            st_d.irq      = 1'b0;
        end
        if (clr_err) begin
            st_d.err_bit = 1'b0;
        end
        if (done_in && st_q.busy) begin
            st_d.busy     = 1'b0;
            st_d.done_bit = 1'b1;
            if (st_q.irq_en) begin
                st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start    = st_q.start;
    assign algo     = st_q.algo;
    assign mode     = st_q.mode;
    assign sg       = st_q.sg;
    assign unsup    = st_q.unsup;
    assign done_bit = st_q.done_bit;
    assign err_bit  = st_q.err_bit;
    assign irq      = st_q.irq;

    assert_start_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> st_q.busy);
    assert_done_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_in && st_q.busy) |=> done_bit);
    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done_in && st_q.busy));
    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !(done_in && st_q.busy)) |=> !irq);
    assert_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && st_q.busy) |=> (err_bit && !start));

endmodule

// File: rtl/hash_ctrl_regs.sv
module hash_ctrl_regs
    import hcr_pkg::*;
#(
    parameter int          ADDR_W   = 10,
    parameter int          DATA_W   = 32,
    parameter int          NUM_REGS = 16,
    parameter logic [31:0] SRC_MASK = 32'h7FFF_FFFF,
    parameter logic [31:0] DST_MASK = 32'h7FFF_FFF8,
    parameter logic [31:0] KEY_MASK = 32'h7FFF_FFF8,
    parameter logic [31:0] LEN_MASK = 32'h0FFF_FFFF,
    parameter logic [31:0] CMD_MASK = 32'h0014_7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              done_in,
    output logic              start,
    output logic [2:0]        start_algo,
    output logic [1:0]        start_mode,
    output logic              start_sg,
    output logic              unsupported,
    output logic [DATA_W-1:0] src_addr,
    output logic [DATA_W-1:0] dst_addr,
    output logic [DATA_W-1:0] key_addr,
    output logic [DATA_W-1:0] src_len,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);
    localparam logic [DATA_W-1:0] M_SRC = DATA_W'(SRC_MASK);
    localparam logic [DATA_W-1:0] M_DST = DATA_W'(DST_MASK);
    localparam logic [DATA_W-1:0] M_KEY = DATA_W'(KEY_MASK);
    localparam logic [DATA_W-1:0] M_LEN = DATA_W'(LEN_MASK);
    localparam logic [DATA_W-1:0] M_CMD = DATA_W'(CMD_MASK);

    typedef struct packed {
        logic [DATA_W-1:0] ccmd;
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] key;
        logic [DATA_W-1:0] len;
        logic [DATA_W-1:0] hcmd;
    } reg_state_t;

    reg_state_t rf_d, rf_q;

    logic              in_range;
    logic              wr_hit;
    logic              cmd_wr;
    logic              accept;
    logic              clr_done;
    logic              clr_err;
    logic              done_bit;
    logic              err_bit;
    logic [DATA_W-1:0] cmd_masked;
    logic [DATA_W-1:0] status;
    hcr_cmd_t          dec;
    hcr_alg_e          op_algo;
    hcr_mode_e         op_mode;

    assign in_range   = addr < LIMIT;
    assign wr_hit     = wr_en && in_range;
    assign cmd_wr     = wr_hit && (addr == ADDR_W'(IDX_HCMD));
    assign clr_done   = wr_hit && (addr == ADDR_W'(IDX_STAT)) && wdata[ST_DONE_BIT];
    assign clr_err    = wr_hit && (addr == ADDR_W'(IDX_STAT)) && wdata[ST_ERR_BIT];
    assign cmd_masked = wdata & M_CMD;

    hcr_cmd_decode u_dec (
        .fam    (cmd_masked[CMD_FAM_LSB +: 3]),
        .sub    (cmd_masked[CMD_SUB_LSB +: 3]),
        .mode   (cmd_masked[CMD_MODE_LSB +: 2]),
        .sg     (cmd_masked[CMD_SG_BIT]),
        .irq_en (cmd_masked[CMD_IRQ_BIT]),
        .casc   (cmd_masked[CMD_CASC_BIT]),
        .dec    (dec)
    );

    hcr_op_ctrl u_op (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .dec      (dec),
        .done_in  (done_in),
        .clr_done (clr_done),
        .clr_err  (clr_err),
        .accept   (accept),
        .start    (start),
        .algo     (op_algo),
        .mode     (op_mode),
        .sg       (start_sg),
        .unsup    (unsupported),
        .done_bit (done_bit),
        .err_bit  (err_bit),
        .irq      (irq)
    );

    always_comb begin
        rf_d = rf_q;
        if (wr_hit) begin
            unique case (addr)
                ADDR_W'(IDX_CCMD): rf_d.ccmd = wdata;
                ADDR_W'(IDX_SRC):  rf_d.src  = wdata & M_SRC;
                ADDR_W'(IDX_DST):  rf_d.dst  = wdata & M_DST;
                ADDR_W'(IDX_KEY):  rf_d.key  = wdata & M_KEY;
                ADDR_W'(IDX_LEN):  rf_d.len  = wdata & M_LEN;
                default: ;
            endcase
        end
        if (accept) begin
            rf_d.hcmd = cmd_masked;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        status              = '0;
        status[ST_DONE_BIT] = done_bit;
        status[ST_ERR_BIT]  = err_bit;
    end

    always_comb begin
        rdata = '0;
        if (rd_en && in_range) begin
            unique case (addr)
                ADDR_W'(IDX_CCMD): rdata = rf_q.ccmd;
                ADDR_W'(IDX_STAT): rdata = status;
                ADDR_W'(IDX_SRC):  rdata = rf_q.src;
                ADDR_W'(IDX_DST):  rdata = rf_q.dst;
                ADDR_W'(IDX_KEY):  rdata = rf_q.key;
                ADDR_W'(IDX_LEN):  rdata = rf_q.len;
                ADDR_W'(IDX_HCMD): rdata = rf_q.hcmd;
                default:           rdata = '0;
            endcase
        end
    end

    assign start_algo = op_algo;
    assign start_mode = op_mode;
    assign src_addr   = rf_q.src;
    assign dst_addr   = rf_q.dst;
    assign key_addr   = rf_q.key;
    assign src_len    = rf_q.len;

    assert_oor_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr >= LIMIT) |-> (rdata == '0));
    assert_dst_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_addr[2:0] == 3'b000) && (key_addr[2:0] == 3'b000));
    assert_len_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_len & ~M_LEN) == '0);
    assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !accept) |=> $stable(rf_q.hcmd));

endmodule

// File: tb/hash_ctrl_regs_test.sv
module hash_ctrl_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;

    // {cmd[47:16], valid nibble, algo nibble, mode nibble, {0,sg,unsup,irq}}
    localparam logic [47:0] VEC [NV] = '{
        48'h00000000_1000,   // MD5
        48'h00000020_1100,   // SHA-1
        48'h00000040_1200,   // SHA-224
        48'h00000250_1301,   // SHA-256 with interrupt
        48'h00000060_1400,   // SHA-512
        48'h00000460_1500,   // SHA-384
        48'h00000860_1600,   // truncated 256
        48'h00000C60_0000,   // bad sub in 64-bit family
        48'h00000030_0000,   // undefined family
        48'h00000450_0000,   // SHA-256 with nonzero sub
        48'h00000150_1320,   // accumulate
        48'h00040020_1104,   // scatter-gather
        48'h00000080_1012,   // HMAC -> unsupported
        48'h00000022_1102,   // cascade bit
        48'h00000180_1032,   // key preparation
        48'h80000020_1100    // bit outside mask
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        done_in = 1'b0;
    logic        start;
    logic [2:0]  start_algo;
    logic [1:0]  start_mode;
    logic        start_sg;
    logic        unsupported;
    logic [31:0] src_addr, dst_addr, key_addr, src_len;
    logic        irq;

    int checks = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hash_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .done_in(done_in), .start(start),
        .start_algo(start_algo), .start_mode(start_mode), .start_sg(start_sg),
        .unsupported(unsupported), .src_addr(src_addr), .dst_addr(dst_addr),
        .key_addr(key_addr), .src_len(src_len), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 10'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = 10'(a);
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        done_in = 1'b1;
        @(negedge clk);
        done_in = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        chk("R12 irq", 32'(irq), 0);
        chk("R12 start", 32'(start), 0);
        foreach (VEC[i]) begin end
        for (int k = 4; k <= 12; k++) begin
            rd(k, r);
            chk("R12 reg", r, 0);
        end

        // R1 / R2: register map and masks
        wr(4, 32'hA5A5_5A5A); rd(4, r); chk("R1 cipher cmd", r, 32'hA5A5_5A5A);
        wr(5, 32'hFFFF_FFFF); rd(5, r); chk("R1 unused word", r, 0);
        wr(8, 32'hFFFF_FFFF); rd(8, r); chk("R2 src mask", r, 32'h7FFF_FFFF);
        chk("R1 src port", src_addr, 32'h7FFF_FFFF);
        wr(9, 32'hFFFF_FFFF); rd(9, r); chk("R2 dst mask", r, 32'h7FFF_FFF8);
        chk("R1 dst port", dst_addr, 32'h7FFF_FFF8);
        wr(10, 32'hFFFF_FFFF); rd(10, r); chk("R2 key mask", r, 32'h7FFF_FFF8);
        chk("R1 key port", key_addr, 32'h7FFF_FFF8);
        wr(11, 32'hFFFF_FFFF); rd(11, r); chk("R2 len mask", r, 32'h0FFF_FFFF);
        chk("R1 len port", src_len, 32'h0FFF_FFFF);

        // R3: out of range
        wr(20, 32'h1234_5678); rd(20, r); chk("R3 oor read", r, 0);
        rd(4, r); chk("R3 oor write no effect", r, 32'hA5A5_5A5A);
        wr(28, 32'h0000_0001); rd(12, r); chk("R3 no alias cmd", r, 0);
        chk("R3 no start", 32'(start), 0);

        // table walk: R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [31:0] cmd;
            cmd = VEC[i][47:16];
            wr(12, cmd);
            chk("R4/R5 start", 32'(start), 32'(VEC[i][12]));
            if (VEC[i][12]) begin
                chk("R4 algo", 32'(start_algo), 32'(VEC[i][10:8]));
                chk("R6 mode", 32'(start_mode), 32'(VEC[i][5:4]));
                chk("R6 sg", 32'(start_sg), 32'(VEC[i][2]));
                chk("R7 unsupported", 32'(unsupported), 32'(VEC[i][1]));
                @(negedge clk);
                chk("R6 one cycle", 32'(start), 0);
                rd(12, r); chk("R2 cmd mask", r, cmd & 32'h0014_7FFF);
                pulse_done();
                rd(7, r); chk("R8 done bit", r, 32'h0000_0200);
                chk("R9 irq follows enable", 32'(irq), 32'(VEC[i][0]));
                wr(7, 32'h0000_0200);
                chk("R9 irq cleared", 32'(irq), 0);
                rd(7, r); chk("R9 status cleared", r, 0);
            end else begin
                pulse_done();
                rd(7, r); chk("R5 no operation", r, 0);
                chk("R5 no irq", 32'(irq), 0);
            end
        end

        // R10: command while busy
        wr(12, 32'h0000_0020);
        chk("R10 first start", 32'(start), 1);
        wr(12, 32'h0000_0040);
        chk("R10 refused start", 32'(start), 0);
        rd(7, r); chk("R10 err bit", r, 32'h0000_0001);
        rd(12, r); chk("R10 cmd unchanged", r, 32'h0000_0020);
        wr(7, 32'h0000_0001);
        rd(7, r); chk("R10 err cleared", r, 0);
        pulse_done();
        wr(7, 32'h0000_0200);

        // R8: done while idle
        pulse_done();
        rd(7, r); chk("R8 idle done ignored", r, 0);

        // R11: ones do not set status bits
        wr(7, 32'hFFFF_FFFF);
        rd(7, r); chk("R11 no set", r, 0);
        chk("R11 no irq", 32'(irq), 0);

        // R12: reset during pending interrupt
        wr(8, 32'h0000_1000);
        wr(12, 32'h0000_0250);
        pulse_done();
        chk("R9 irq before reset", 32'(irq), 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R12 irq dropped", 32'(irq), 0);
        rd(7, r); chk("R12 status", r, 0);
        rd(8, r); chk("R12 src", r, 0);
        rd(12, r); chk("R12 cmd", r, 0);
        wr(12, 32'h0000_0020);
        chk("R12 idle after reset", 32'(start), 1);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule